// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Masked Status Flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit microcontroller core. Each cycle it receives two operands, a 5-bit operation code and the current carry and zero flags from the status register. It returns a result, a write-enable that tells the register file whether to store that result, six flag values, and a six-bit update mask. The status register loads only the flags whose mask bit is set and keeps the others.

Every operation updates a fixed subset of the flags. Subtract-with-carry and compare-with-carry take the incoming carry as a borrow and AND the new zero condition with the incoming zero flag. This lets a chain of byte operations compare or subtract wide values. Compares set the flags but never assert the write-enable. Immediate forms have their own codes and behave the same as their register forms. The caller puts the constant on `b_i`.

Top module: `alu8_core`

## Requirements
- R1: Opcode encoding: 0 ADD, 1 ADC, 2 SUB, 3 SUBI, 4 SBC, 5 SBCI, 6 AND, 7 ANDI, 8 OR, 9 ORI, 10 XOR, 11 COM, 12 NEG, 13 SBR, 14 CBR, 15 INC, 16 DEC, 17 TST, 18 CLR, 19 SER, 20 CP, 21 CPC, 22 CPI. `wr_en_o` is 1 for codes 0 to 19. It is 0 for the compares 20 to 22 and for the unused codes 23 to 31.
- R2: ADD gives a+b and ADC gives a+b+c_i, each modulo 256. C is the carry out of bit 7, H is the carry out of bit 3 and V is signed overflow. Flag vector bit positions are 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H. Z is (result==0) and N is result bit 7. The update mask for these codes is 0x3F.
- R3: SUB, SUBI, CP and CPI compute a-b. SBC, SBCI and CPC compute a-b-c_i. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow. The mask is 0x3F, and the result port carries the difference for the compares too.
- R4: For SBC, SBCI and CPC, Z is 1 only when the difference is zero and z_i is 1. For all other codes Z does not depend on z_i.
- R5: AND, ANDI, OR, ORI, XOR, SBR (a|b), CBR (a & ~b), TST (a) and CLR (0) force V to 0. Their mask is 0x1E, so C and H are not updated.
- R6: COM gives 0xFF-a and forces C to 1 and V to 0. Its mask is 0x1F.
- R7: NEG gives 0x00-a. C is 1 when the result is nonzero, H is the borrow out of bit 3, and V is 1 only for a result of 0x80. Its mask is 0x3F.
- R8: INC gives a+1 and DEC gives a-1, modulo 256. Their mask is 0x1E. V is 1 only when INC moves 0x7F to 0x80 or DEC moves 0x80 to 0x7F.
- R9: SER gives 0xFF and its update mask is 0, so no flag changes.
- R10: When the S mask bit is set, S equals N XOR V. Every flag bit whose mask bit is 0 reads 0.
- R11: Unused codes 23 to 31 give result 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (encoding in R1) |
| a_i | input | DATA_W | Destination-register operand |
| b_i | input | DATA_W | Source-register operand or immediate constant |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag, used by the chained codes |
| res_o | output | DATA_W | Operation result |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| upd_o | output | 6 | Per-flag update mask, same bit order |

## Verification
The bench uses the default DATA_W of 8. At that width the bit-3 half carry, the 0x7F/0x80 signed boundary and the 0xFF wrap all sit where the flag rules place them. It sweeps all 32 opcode values against a set of 18 operand values on each side. The set holds the nibble and sign boundaries (0x0F, 0x10, 0x7F, 0x80, 0xFF and their neighbours) and some scattered values. Each pair is run with all four combinations of incoming carry and zero. This covers borrow chaining, the Z gating of the chained codes and the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int NUM_FLAGS = 6;
    localparam int FLAG_C    = 0;
    localparam int FLAG_Z    = 1;
    localparam int FLAG_N    = 2;
    localparam int FLAG_V    = 3;
    localparam int FLAG_S    = 4;
    localparam int FLAG_H    = 5;

    localparam logic [NUM_FLAGS-1:0] MASK_NONE  = 6'b000000;
    localparam logic [NUM_FLAGS-1:0] MASK_ARITH = 6'b111111;
    localparam logic [NUM_FLAGS-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [NUM_FLAGS-1:0] MASK_COMPL = 6'b011111;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBI = 5'd3,
        OP_SBC  = 5'd4,
        OP_SBCI = 5'd5,
        OP_AND  = 5'd6,
        OP_ANDI = 5'd7,
        OP_OR   = 5'd8,
        OP_ORI  = 5'd9,
        OP_XOR  = 5'd10,
        OP_COM  = 5'd11,
        OP_NEG  = 5'd12,
        OP_SBR  = 5'd13,
        OP_CBR  = 5'd14,
        OP_INC  = 5'd15,
        OP_DEC  = 5'd16,
        OP_TST  = 5'd17,
        OP_CLR  = 5'd18,
        OP_SER  = 5'd19,
        OP_CP   = 5'd20,
        OP_CPC  = 5'd21,
        OP_CPI  = 5'd22
    } alu_op_e;

    typedef enum logic [2:0] {
        LG_AND  = 3'd0,
        LG_OR   = 3'd1,
        LG_XOR  = 3'd2,
        LG_ANDN = 3'd3,
        LG_PASS = 3'd4,
        LG_NOT  = 3'd5,
        LG_ZERO = 3'd6,
        LG_ONES = 3'd7
    } logic_fn_e;

    typedef struct packed {
        logic                  arith;    // result comes from the adder
        logic                  sub;      // adder subtracts
        logic                  use_cin;  // carry flag enters the adder
        logic                  neg;      // operands become 0 and a
        logic                  unit_b;   // second operand forced to 1
        logic                  z_chain;  // zero flag ANDed with z_i
        logic                  c_one;    // carry forced to 1
        logic                  write;    // result is written back
        logic_fn_e             lfn;      // logic unit function
        logic [NUM_FLAGS-1:0]  mask;     // flags updated
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [4:0] code);
        alu_ctrl_t c;
        c      = '0;
        c.lfn  = LG_ZERO;
        c.mask = MASK_NONE;
        case (code)
            OP_ADD, OP_ADC: begin
                c.arith   = 1'b1;
                c.use_cin = (code == OP_ADC);
                c.write   = 1'b1;
                c.mask    = MASK_ARITH;
            end
            OP_SUB, OP_SUBI, OP_CP, OP_CPI: begin
                c.arith = 1'b1;
                c.sub   = 1'b1;
                c.write = (code == OP_SUB) || (code == OP_SUBI);
                c.mask  = MASK_ARITH;
            end
            OP_SBC, OP_SBCI, OP_CPC: begin
                c.arith   = 1'b1;
                c.sub     = 1'b1;
                c.use_cin = 1'b1;
                c.z_chain = 1'b1;
                c.write   = (code != OP_CPC);
                c.mask    = MASK_ARITH;
            end
            OP_NEG: begin
                c.arith = 1'b1;
                c.sub   = 1'b1;
                c.neg   = 1'b1;
                c.write = 1'b1;
                c.mask  = MASK_ARITH;
            end
            OP_INC, OP_DEC: begin
                c.arith  = 1'b1;
                c.sub    = (code == OP_DEC);
                c.unit_b = 1'b1;
                c.write  = 1'b1;
                c.mask   = MASK_LOGIC;
            end
            OP_AND, OP_ANDI: begin
                c.lfn = LG_AND;  c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_OR, OP_ORI, OP_SBR: begin
                c.lfn = LG_OR;   c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_XOR: begin
                c.lfn = LG_XOR;  c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_CBR: begin
                c.lfn = LG_ANDN; c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_TST: begin
                c.lfn = LG_PASS; c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_CLR: begin
                c.lfn = LG_ZERO; c.write = 1'b1; c.mask = MASK_LOGIC;
            end
            OP_COM: begin
                c.lfn   = LG_NOT;
                c.c_one = 1'b1;
                c.write = 1'b1;
                c.mask  = MASK_COMPL;
            end
            OP_SER: begin
                c.lfn = LG_ONES; c.write = 1'b1; c.mask = MASK_NONE;
            end
            default: begin
                c.lfn  = LG_ZERO;
                c.mask = MASK_NONE;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_o,
    output logic              h_o,
    output logic              v_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] y_eff;
    logic              cin_eff;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   low;

    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        cin_eff = sub_i ? ~cin_i : cin_i;
        full    = {1'b0, x_i} + {1'b0, y_eff} + {{DATA_W{1'b0}}, cin_eff};
        low     = {1'b0, x_i[HALF_W-1:0]} + {1'b0, y_eff[HALF_W-1:0]}
                + {{HALF_W{1'b0}}, cin_eff};
        sum_o   = full[DATA_W-1:0];
        // carry for add, borrow (inverted carry) for subtract
        c_o     = sub_i ? ~full[DATA_W] : full[DATA_W];
        h_o     = sub_i ? ~low[HALF_W]  : low[HALF_W];
        v_o     = (x_i[DATA_W-1] == y_eff[DATA_W-1]) &&
                  (full[DATA_W-1] != x_i[DATA_W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic_fn_e         fn_i,
    output logic [DATA_W-1:0] out_o
);
    always_comb begin
        case (fn_i)
            LG_AND:  out_o = x_i & y_i;
            LG_OR:   out_o = x_i | y_i;
            LG_XOR:  out_o = x_i ^ y_i;
            LG_ANDN: out_o = x_i & ~y_i;
            LG_PASS: out_o = x_i;
            LG_NOT:  out_o = ~x_i;
            LG_ONES: out_o = {DATA_W{1'b1}};
            default: out_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]    res_i,
    input  logic                 arith_i,
    input  logic                 c_i,
    input  logic                 h_i,
    input  logic                 v_i,
    input  logic                 c_one_i,
    input  logic                 z_chain_i,
    input  logic                 z_prev_i,
    input  logic [NUM_FLAGS-1:0] mask_i,
    output logic [NUM_FLAGS-1:0] flags_o
);
    logic [NUM_FLAGS-1:0] raw;

    always_comb begin
        raw         = '0;
        raw[FLAG_Z] = (res_i == '0) && (!z_chain_i || z_prev_i);
        raw[FLAG_N] = res_i[DATA_W-1];
        raw[FLAG_V] = arith_i && v_i;
        raw[FLAG_C] = c_one_i || c_i;
        raw[FLAG_H] = h_i;
        raw[FLAG_S] = raw[FLAG_N] ^ raw[FLAG_V];
        flags_o     = raw & mask_i;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [5:0]        flags_o,
    output logic [5:0]        upd_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] add_x, add_y, sum, lres;
    logic              add_cin, add_c, add_h, add_v;

    always_comb begin
        ctrl    = decode_op(op_i);
        add_x   = ctrl.neg ? '0 : a_i;
        add_y   = ctrl.neg ? a_i : (ctrl.unit_b ? ONE : b_i);
        add_cin = ctrl.use_cin && c_i;
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i   (add_x),
        .y_i   (add_y),
        .cin_i (add_cin),
        .sub_i (ctrl.sub),
        .sum_o (sum),
        .c_o   (add_c),
        .h_o   (add_h),
        .v_o   (add_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .x_i   (a_i),
        .y_i   (b_i),
        .fn_i  (ctrl.lfn),
        .out_o (lres)
    );

    always_comb begin
        res_o   = ctrl.arith ? sum : lres;
        wr_en_o = ctrl.write;
        upd_o   = ctrl.mask;
    end

    alu8_flags #(.DATA_W(DATA_W)) u_flags (
        .res_i     (res_o),
        .arith_i   (ctrl.arith),
        .c_i       (add_c),
        .h_i       (add_h),
        .v_i       (add_v),
        .c_one_i   (ctrl.c_one),
        .z_chain_i (ctrl.z_chain),
        .z_prev_i  (z_i),
        .mask_i    (ctrl.mask),
        .flags_o   (flags_o)
    );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              c_i,
    input logic              z_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [5:0]        flags_o,
    input logic [5:0]        upd_o
);
    logic known;

    always_comb begin
        known = !$isunknown({op_i, a_i, b_i, c_i, z_i});
        if (known) begin
            // R1: compares never write back
            assert_cmp_nowrite_R1: assert (!(op_i >= 5'd20 && op_i <= 5'd22) || !wr_en_o);
            // R4: a cleared incoming zero keeps Z cleared on chained codes
            assert_chain_z_R4: assert (!((op_i == 5'd4 || op_i == 5'd5 || op_i == 5'd21) && !z_i)
                                       || !flags_o[FLAG_Z]);
            // R5: logic codes never report overflow
            assert_logic_v_R5: assert (!(op_i inside {5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd13,
                                                      5'd14, 5'd17, 5'd18}) || !flags_o[FLAG_V]);
            // R6: complement sets carry
            assert_com_carry_R6: assert (op_i != 5'd11 || (flags_o[FLAG_C] && !flags_o[FLAG_V]));
            // R9: set-all writes ones and touches no flag
            assert_ser_R9: assert (op_i != 5'd19 || (res_o == {DATA_W{1'b1}} && upd_o == '0));
            // R10: masked-off flags read zero and S tracks N xor V
            assert_masked_zero_R10: assert ((flags_o & ~upd_o) == '0);
            assert_sign_R10: assert (!upd_o[FLAG_S] ||
                                     flags_o[FLAG_S] == (flags_o[FLAG_N] ^ flags_o[FLAG_V]));
            // R11: unused codes are inert
            assert_unused_R11: assert (op_i < 5'd23 || (!wr_en_o && upd_o == '0 && res_o == '0));
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .z_i     (z_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .flags_o (flags_o),
    .upd_o   (upd_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    localparam int DATA_W = 8;
    localparam int MAX_CYCLES = 190000;

    typedef struct {
        int       op;
        int       a;
        int       b;
        int       res;
        bit       wr;
        bit [5:0] flags;
        bit [5:0] mask;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        op_i = '0;
    logic [DATA_W-1:0] a_i = '0;
    logic [DATA_W-1:0] b_i = '0;
    logic              c_i = 1'b0;
    logic              z_i = 1'b0;
    logic [DATA_W-1:0] res_o;
    logic              wr_en_o;
    logic [5:0]        flags_o;
    logic [5:0]        upd_o;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    alu8_core #(.DATA_W(DATA_W)) dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .z_i(z_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .upd_o(upd_o)
    );

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 1) return "R2";
        if (op <= 5 || (op >= 20 && op <= 22)) return "R3";
        if (op == 11) return "R6";
        if (op == 12) return "R7";
        if (op == 15 || op == 16) return "R8";
        if (op == 19) return "R9";
        if (op >= 23) return "R11";
        return "R5";
    endfunction

    // Reference model written from the requirements
    function automatic item_t model(input int op, input int a, input int b,
                                    input int c, input int z);
        item_t it;
        int full, lo, sr, cin, x, y, r;
        bit cf, hf, vf, zf, nf, chain;
        it.op = op; it.a = a; it.b = b;
        cf = 0; hf = 0; vf = 0; chain = 0; r = 0;
        it.wr = (op <= 19);
        it.mask = 6'h00;
        case (op)
            0, 1: begin
                cin  = (op == 1) ? c : 0;
                full = a + b + cin;
                r    = full & 255;
                cf   = full > 255;
                hf   = ((a & 15) + (b & 15) + cin) > 15;
                sr   = sgn(a) + sgn(b) + cin;
                vf   = (sr > 127) || (sr < -128);
                it.mask = 6'h3F;
            end
            2, 3, 4, 5, 12, 20, 21, 22: begin
                chain = (op == 4 || op == 5 || op == 21);
                cin   = chain ? c : 0;
                x     = (op == 12) ? 0 : a;
                y     = (op == 12) ? a : b;
                full  = x - y - cin;
                r     = full & 255;
                cf    = full < 0;
                hf    = ((x & 15) - (y & 15) - cin) < 0;
                sr    = sgn(x) - sgn(y) - cin;
                vf    = (sr > 127) || (sr < -128);
                it.mask = 6'h3F;
            end
            6, 7:   begin r = a & b;          it.mask = 6'h1E; end
            8, 9:   begin r = a | b;          it.mask = 6'h1E; end
            10:     begin r = a ^ b;          it.mask = 6'h1E; end
            13:     begin r = a | b;          it.mask = 6'h1E; end
            14:     begin r = a & (255 - b);  it.mask = 6'h1E; end
            17:     begin r = a;              it.mask = 6'h1E; end
            18:     begin r = 0;              it.mask = 6'h1E; end
            11:     begin r = 255 - a; cf = 1; it.mask = 6'h1F; end
            15:     begin r = (a + 1) & 255;   vf = (a == 127); it.mask = 6'h1E; end
            16:     begin r = (a + 255) & 255; vf = (a == 128); it.mask = 6'h1E; end
            19:     begin r = 255; end
            default: begin r = 0; end
        endcase
        zf = (r == 0) && (!chain || z != 0);
        nf = r > 127;
        it.res   = r;
        it.flags = {hf, nf ^ vf, vf, nf, zf, cf} & it.mask;
        return it;
    endfunction

    task automatic drive(input int op, input int a, input int b, input int c, input int z);
        @(posedge clk);
        #1;
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0]; z_i = z[0];
        sb_q.push_back(model(op, a, b, c, z));
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp,
                       input item_t it);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%0h b=%0h c=%0b z=%0b actual=%0h expected=%0h",
                     req, what, it.op, it.a, it.b, c_i, z_i, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            string t;
            it = sb_q.pop_front();
            t  = tag_of(it.op);
            chk(t, "result", int'(res_o), it.res, it);
            chk(it.op >= 23 ? "R11" : "R1", "wr_en", int'(wr_en_o), int'(it.wr), it);
            chk(t, "mask", int'(upd_o), int'(it.mask), it);
            for (int k = 0; k < 6; k++) begin
                string ft;
                if (!it.mask[k] || k == 4)                               ft = "R10";
                else if (k == 1 && (it.op == 4 || it.op == 5 || it.op == 21)) ft = "R4";
                else                                                     ft = t;
                chk(ft, $sformatf("flag%0d", k), int'(flags_o[k]), int'(it.flags[k]), it);
            end
        end
    end

    function automatic int pick(input int i);
        case (i)
            0: return 8'h00;   1: return 8'h01;   2: return 8'h0F;   3: return 8'h10;
            4: return 8'h7F;   5: return 8'h80;   6: return 8'h81;   7: return 8'hFE;
            8: return 8'hFF;   9: return 8'h08;  10: return 8'h3C;  11: return 8'h55;
           12: return 8'hAA;  13: return 8'h6E;  14: return 8'hC3;  15: return 8'h9D;
           16: return 8'h40;  17: return 8'hF0;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero add, then named corner cases
        drive(0, 0, 0, 0, 0);            // R2 zero result sets Z
        drive(0, 8'h7F, 8'h01, 0, 0);    // R2 signed overflow and half carry
        drive(1, 8'hFF, 8'h00, 1, 0);    // R2 carry-in wraps to zero
        drive(2, 8'h10, 8'h01, 0, 0);    // R3 half borrow
        drive(21, 8'h05, 8'h05, 0, 0);   // R4 equal bytes but z_i=0 keeps Z low
        drive(21, 8'h05, 8'h05, 0, 1);   // R4 equal bytes with z_i=1
        drive(22, 8'h03, 8'h09, 0, 0);   // R1 compare does not write; R3 borrow
        drive(10, 8'hA5, 8'hA5, 1, 1);   // R5 xor to zero, C not updated
        drive(11, 8'h00, 8'h00, 0, 0);   // R6 complement of zero
        drive(12, 8'h80, 8'h00, 0, 0);   // R7 negate 0x80 overflows
        drive(12, 8'h00, 8'h00, 1, 0);   // R7 negate zero clears C
        drive(15, 8'h7F, 8'h00, 0, 0);   // R8 increment overflow
        drive(16, 8'h80, 8'h00, 0, 0);   // R8 decrement overflow
        drive(19, 8'h12, 8'h34, 1, 1);   // R9 set all
        drive(27, 8'hFF, 8'hFF, 1, 1);   // R11 unused code
        // sweep
        for (int op = 0; op < 32; op++)
            for (int ai = 0; ai < 18; ai++)
                for (int bi = 0; bi < 18; bi++)
                    for (int cz = 0; cz < 4; cz++)
                        drive(op, pick(ai), pick(bi), cz & 1, cz >> 1);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule